// File: doc/BRIEF.md
# Receive Character Queue with Status Mode

This block buffers received characters for one serial channel. Each character arrives from the UART receiver together with four error bits (break, framing, overrun, parity). The block keeps the character and its error bits together in a queue of up to 1023 entries. The host drains the queue through a 16-bit read word. The layout of that word depends on a mode input: it is either one character plus its error bits, or two characters packed side by side.

The block shows the number of characters it holds. It raises a data-available flag whenever the queue is not empty. It also raises a fill trigger against a level chosen from four settings. If a character arrives while the queue is full, the block drops it and sets a sticky overflow flag. A clear input resets the count, the read and write positions and the overflow flag. An enable input gates intake.

Top module: `rxq_status_fifo`

## Requirements
- R1: After reset, `count_o` is 0, and `avail_o`, `trig_o`, `ovf_o` and `rd_word_o` are all 0.
- R2: When `en_i` is high and the queue is not full, a cycle with `wr_valid_i` high stores `wr_data_i` together with `wr_err_i`, and `count_o` rises by one at the next clock.
- R3: When `stat_mode_i` is high, `rd_word_o[7:0]` is the oldest character and `rd_word_o[11:8]` is its error bits. In that nibble bit 11 is break, bit 10 is framing, bit 9 is overrun and bit 8 is parity, taken from `wr_err_i[3:0]` in the same order. Bits 15:12 are 0. A cycle with `rd_i` high removes exactly one entry.
- R4: When `stat_mode_i` is low, `rd_word_o[7:0]` is the oldest character and `rd_word_o[15:8]` is the next one, and `rd_i` removes two entries. If only one entry is held, the high byte reads 0 and `rd_i` removes that one entry.
- R5: While the queue is empty, `rd_word_o` reads 0 and `rd_i` has no effect on the count.
- R6: The queue is full when `count_o` is 1023. A write while the queue is enabled and full is dropped, leaves the stored contents unchanged and sets `ovf_o`. `ovf_o` stays set until `clr_i`. Fullness is judged on the count at the start of the cycle, even if a read happens in the same cycle.
- R7: While `en_i` is low, incoming characters are dropped, are not counted and do not set `ovf_o`. Reads continue to work.
- R8: `trig_sel_i` sets the trigger as follows:
  - 0: `trig_o` stays 0.
  - 1: `trig_o` is high for a count of at least 1.
  - 2: `trig_o` is high for a count of at least 512.
  - 3: `trig_o` is high for a count of at least 896.
- R9: `avail_o` is high exactly when `count_o` is non-zero.
- R10: A cycle with `clr_i` high empties the queue and clears `ovf_o` at the next clock. It takes priority over any read or write in the same cycle.
- R11: A read and an accepted write in the same cycle take effect together: the count changes by one minus the number of entries popped.
- R12: Characters leave in arrival order, including after the storage positions wrap past the last entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Intake enable |
| clr_i | input | 1 | Clear count, positions and overflow |
| stat_mode_i | input | 1 | 1: character plus status per read; 0: two characters per read |
| trig_sel_i | input | 2 | Trigger level select |
| wr_valid_i | input | 1 | Received character strobe |
| wr_data_i | input | 8 | Received character |
| wr_err_i | input | 4 | Error bits {break, framing, overrun, parity} |
| rd_i | input | 1 | Pop strobe for the current read word |
| rd_word_o | output | 16 | Read word for the head of the queue |
| count_o | output | 10 | Number of characters held |
| avail_o | output | 1 | Data available |
| trig_o | output | 1 | Fill level reached |
| ovf_o | output | 1 | Sticky overflow |

## Verification
The bench goes after the cases where a design is most likely to go wrong:
- A two-character read when only one character is held. A faulty design would underflow the count or show stale data in the high byte.
- A write that meets a full queue in the same cycle as a read. A design that judges fullness after the pop would accept the character and leave the overflow flag clear.
- Storage that wraps past its last entry, which breaks ordering if the read position is advanced wrongly by two.
- A clear in the same cycle as a write. If the clear loses priority, the count ends at 1.
- The exact threshold counts for the half and seven-eighths triggers, where an off-by-one compare would move the edge by one character.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef struct packed {
    logic [3:0] err;   // {break, framing, overrun, parity}
    logic [7:0] data;
  } rxq_entry_t;

  typedef enum logic [1:0] {
    TRIG_OFF  = 2'd0,
    TRIG_ONE  = 2'd1,
    TRIG_HALF = 2'd2,
    TRIG_7_8  = 2'd3
  } trig_sel_e;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 1023,
  parameter int AW    = 10
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  rxq_entry_t       wdata_i,
  input  logic [AW-1:0]    raddr0_i,
  input  logic [AW-1:0]    raddr1_i,
  output rxq_entry_t       rdata0_o,
  output rxq_entry_t       rdata1_o
);
  rxq_entry_t mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata0_o = mem_q[raddr0_i];
  assign rdata1_o = mem_q[raddr1_i];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int DEPTH = 1023,
  parameter int AW    = 10,
  parameter int CW    = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic          stat_mode_i,
  input  logic          wr_valid_i,
  input  logic          rd_i,
  output logic          we_o,
  output logic [AW-1:0] wptr_o,
  output logic [AW-1:0] rptr_o,
  output logic [AW-1:0] rptr_nx_o,
  output logic          have_one_o,
  output logic          have_two_o,
  output logic [CW-1:0] count_o,
  output logic          ovf_o
);
  localparam logic [AW-1:0] LAST   = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_N = CW'(DEPTH);

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  logic [AW-1:0] wptr_q, rptr_q, wptr_d, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q;
  logic          full, push, drop, pop_one, pop_two;

  assign full    = (cnt_q == FULL_N);
  assign push    = wr_valid_i && en_i && !full && !clr_i;
  assign drop    = wr_valid_i && en_i && full;
  assign have_one_o = (cnt_q != '0);
  assign have_two_o = (cnt_q > CW'(1));
  // two-byte mode pops a pair when available, else the single remaining entry
  assign pop_two = rd_i && !stat_mode_i && have_two_o;
  assign pop_one = rd_i && have_one_o && !pop_two;

  always_comb begin
    wptr_d = push ? ptr_inc(wptr_q) : wptr_q;
    rptr_d = rptr_q;
    if (pop_two)      rptr_d = ptr_inc(ptr_inc(rptr_q));
    else if (pop_one) rptr_d = ptr_inc(rptr_q);
    cnt_d = cnt_q;
    if (push)         cnt_d = cnt_d + 1'b1;
    if (pop_two)      cnt_d = cnt_d - CW'(2);
    else if (pop_one) cnt_d = cnt_d - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else if (clr_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
      ovf_q  <= ovf_q | drop;
    end
  end

  assign we_o      = push;
  assign wptr_o    = wptr_q;
  assign rptr_o    = rptr_q;
  assign rptr_nx_o = ptr_inc(rptr_q);
  assign count_o   = cnt_q;
  assign ovf_o     = ovf_q;
endmodule

// File: rtl/rxq_fmt.sv
module rxq_fmt
  import rxq_pkg::*;
(
  input  logic        stat_mode_i,
  input  logic        have_one_i,
  input  logic        have_two_i,
  input  rxq_entry_t  head_i,
  input  rxq_entry_t  next_i,
  output logic [15:0] word_o
);
  always_comb begin
    word_o = '0;
    if (have_one_i) begin
      if (stat_mode_i) word_o = {4'b0000, head_i.err, head_i.data};
      else             word_o = {have_two_i ? next_i.data : 8'h00, head_i.data};
    end
  end
endmodule

// File: rtl/rxq_trig.sv
module rxq_trig
  import rxq_pkg::*;
#(
  parameter int DEPTH = 1023,
  parameter int CW    = 10
) (
  input  logic [1:0]    trig_sel_i,
  input  logic [CW-1:0] count_i,
  output logic          trig_o
);
  localparam int            SLOTS    = DEPTH + 1;
  localparam logic [CW-1:0] LVL_HALF = CW'(SLOTS / 2);
  localparam logic [CW-1:0] LVL_7_8  = CW'((SLOTS * 7) / 8);

  trig_sel_e sel;
  assign sel = trig_sel_e'(trig_sel_i);

  always_comb begin
    unique case (sel)
      TRIG_OFF:  trig_o = 1'b0;
      TRIG_ONE:  trig_o = (count_i != '0);
      TRIG_HALF: trig_o = (count_i >= LVL_HALF);
      TRIG_7_8:  trig_o = (count_i >= LVL_7_8);
      default:   trig_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/rxq_status_fifo.sv
module rxq_status_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH = 1023,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          clr_i,
  input  logic          stat_mode_i,
  input  logic [1:0]    trig_sel_i,
  input  logic          wr_valid_i,
  input  logic [7:0]    wr_data_i,
  input  logic [3:0]    wr_err_i,
  input  logic          rd_i,
  output logic [15:0]   rd_word_o,
  output logic [CW-1:0] count_o,
  output logic          avail_o,
  output logic          trig_o,
  output logic          ovf_o
);
  logic          we, have_one, have_two;
  logic [AW-1:0] wptr, rptr, rptr_nx;
  rxq_entry_t    wentry, head, next;

  assign wentry = '{err: wr_err_i, data: wr_data_i};

  rxq_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) ctrl_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr_i),
    .en_i        (en_i),
    .stat_mode_i (stat_mode_i),
    .wr_valid_i  (wr_valid_i),
    .rd_i        (rd_i),
    .we_o        (we),
    .wptr_o      (wptr),
    .rptr_o      (rptr),
    .rptr_nx_o   (rptr_nx),
    .have_one_o  (have_one),
    .have_two_o  (have_two),
    .count_o     (count_o),
    .ovf_o       (ovf_o)
  );

  rxq_store #(.DEPTH(DEPTH), .AW(AW)) store_i (
    .clk_i    (clk_i),
    .we_i     (we),
    .waddr_i  (wptr),
    .wdata_i  (wentry),
    .raddr0_i (rptr),
    .raddr1_i (rptr_nx),
    .rdata0_o (head),
    .rdata1_o (next)
  );

  rxq_fmt fmt_i (
    .stat_mode_i (stat_mode_i),
    .have_one_i  (have_one),
    .have_two_i  (have_two),
    .head_i      (head),
    .next_i      (next),
    .word_o      (rd_word_o)
  );

  rxq_trig #(.DEPTH(DEPTH), .CW(CW)) trig_i (
    .trig_sel_i (trig_sel_i),
    .count_i    (count_o),
    .trig_o     (trig_o)
  );

  assign avail_o = have_one;
endmodule

// File: rtl/rxq_status_fifo_chk.sv
module rxq_status_fifo_chk #(
  parameter int DEPTH = 1023,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          clr_i,
  input logic          wr_valid_i,
  input logic          rd_i,
  input logic [1:0]    trig_sel_i,
  input logic [CW-1:0] count_o,
  input logic          avail_o,
  input logic          trig_o,
  input logic          ovf_o
);
  localparam logic [CW-1:0] FULL_N = CW'(DEPTH);

  a_r6_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= FULL_N);

  a_r6_ovf_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && en_i && count_o == FULL_N && !clr_i) |=> ovf_o);

  a_r6_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !clr_i) |=> ovf_o);

  a_r6_full_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == FULL_N && !rd_i && !clr_i) |=> count_o == FULL_N);

  a_r7_disabled_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !rd_i && !clr_i) |=> $stable(count_o) && ($past(ovf_o) == ovf_o));

  a_r5_empty_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == '0 && !(wr_valid_i && en_i) && !clr_i) |=> count_o == '0);

  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (count_o == '0) && !ovf_o && !avail_o);

  a_r8_trig_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_sel_i == 2'd1) |-> (trig_o == avail_o));

  a_r8_trig_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_sel_i == 2'd0) |-> !trig_o);
endmodule

bind rxq_status_fifo rxq_status_fifo_chk #(.DEPTH(DEPTH)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .clr_i      (clr_i),
  .wr_valid_i (wr_valid_i),
  .rd_i       (rd_i),
  .trig_sel_i (trig_sel_i),
  .count_o    (count_o),
  .avail_o    (avail_o),
  .trig_o     (trig_o),
  .ovf_o      (ovf_o)
);

// File: tb/rxq_status_fifo_tb_top.sv
module rxq_status_fifo_tb_top;
  localparam int DEPTH = 1023;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0, clr_i = 1'b0, stat_mode_i = 1'b0;
  logic [1:0]  trig_sel_i = 2'd0;
  logic        wr_valid_i = 1'b0, rd_i = 1'b0;
  logic [7:0]  wr_data_i = '0;
  logic [3:0]  wr_err_i = '0;
  logic [15:0] rd_word_o;
  logic [9:0]  count_o;
  logic        avail_o, trig_o, ovf_o;

  always #5 clk_i = ~clk_i;

  rxq_status_fifo #(.DEPTH(DEPTH)) dut_i (.*);

  int    n_vec = 0, n_bad = 0, seq = 0;
  string tag = "R1";
  logic [11:0] mq[$];
  logic        m_ovf = 1'b0;

  task automatic chk(string rq, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s (scenario %s) actual=%0h expected=%0h", rq, tag, act, exp);
    end
  endtask

  task automatic compare_all();
    int sz = mq.size();
    int w = 0, t = 0;
    if (sz > 0) begin
      if (stat_mode_i) w = {4'b0, mq[0]};
      else w = {(sz > 1) ? mq[1][7:0] : 8'h00, mq[0][7:0]};
    end
    case (trig_sel_i)
      2'd1: t = int'(sz >= 1);
      2'd2: t = int'(sz >= (DEPTH + 1) / 2);
      2'd3: t = int'(sz >= ((DEPTH + 1) * 7) / 8);
      default: t = 0;
    endcase
    chk(stat_mode_i ? "R3" : "R4", int'(rd_word_o), w);
    chk("R2", int'(count_o), sz);
    chk("R9", int'(avail_o), int'(sz != 0));
    chk("R8", int'(trig_o), t);
    chk("R6", int'(ovf_o), int'(m_ovf));
  endtask

  // one clock: drive at negedge, model after posedge, compare at next negedge
  task automatic step(logic wv, logic rd, logic clr);
    logic [11:0] ent;
    int sz;
    ent = {seq[3:0], seq[7:0] ^ 8'h5A};
    wr_valid_i = wv; rd_i = rd; clr_i = clr;
    wr_data_i = ent[7:0]; wr_err_i = ent[11:8];
    @(posedge clk_i);
    sz = mq.size();
    if (clr) begin
      mq.delete(); m_ovf = 1'b0;
    end else begin
      if (rd && sz > 0) begin
        void'(mq.pop_front());
        if (!stat_mode_i && sz > 1) void'(mq.pop_front());
      end
      if (wv && en_i) begin
        if (sz == DEPTH) m_ovf = 1'b1;
        else mq.push_back(ent);
      end
    end
    if (wv) seq++;
    @(negedge clk_i);
    wr_valid_i = 1'b0; rd_i = 1'b0; clr_i = 1'b0;
    compare_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog expired in scenario %s", tag);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    tag = "R1";
    compare_all();
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare_all();

    // R2 / R3: status mode, one entry per read
    tag = "R3"; en_i = 1'b1; stat_mode_i = 1'b1; trig_sel_i = 2'd1;
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 1'b0);

    // R5: read while empty
    tag = "R5";
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b0);

    // R4: pair reads, odd remainder
    tag = "R4"; stat_mode_i = 1'b0;
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b0);

    // R7: intake disabled
    tag = "R7"; en_i = 1'b0;
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0);
    en_i = 1'b1;
    step(1'b1, 1'b0, 1'b0);
    en_i = 1'b0;
    step(1'b1, 1'b1, 1'b0);
    en_i = 1'b1;

    // R11: read and write in the same cycle
    tag = "R11"; stat_mode_i = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 1'b0);
    stat_mode_i = 1'b0;
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b0);

    // R8: trigger thresholds while filling, then full and overflow
    tag = "R8"; trig_sel_i = 2'd2;
    while (mq.size() < 895) begin
      if (mq.size() == 600) trig_sel_i = 2'd3;
      step(1'b1, 1'b0, 1'b0);
    end
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    trig_sel_i = 2'd0;
    step(1'b1, 1'b0, 1'b0);
    tag = "R6"; trig_sel_i = 2'd3;
    while (mq.size() < DEPTH) step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    stat_mode_i = 1'b1;
    step(1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b0);

    // R10: clear wins over a same-cycle write
    tag = "R10";
    step(1'b1, 1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b0);

    // R12: order across wrap of storage positions
    tag = "R12"; trig_sel_i = 2'd2;
    while (mq.size() < DEPTH) step(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 600; i++) step(1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 500; i++) step(1'b1, 1'b0, 1'b0);
    stat_mode_i = 1'b0;
    while (mq.size() > 0) step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule